// File: doc/BRIEF.md
# Descriptor-Ring DMA Channel Sequencer

This block controls one bus-master audio DMA channel that walks a circular list of buffer descriptors. It holds the channel's current descriptor index, the last index that software has marked usable, a status word and a small control word. A separate fetch engine does the bus work and reports back through a few strobes: a buffer has finished, whether that buffer's descriptor asked for an interrupt on completion, whether the sample FIFO ran dry or overflowed, and whether a bus transaction is still outstanding.

Software fills descriptors, moves the last-valid index forward and sets the run bit. The sequencer steps the current index on each finished buffer and wraps it at the end of the ring. It stops by itself after the buffer at the last-valid index finishes. When software clears the run bit, the sequencer stops once any outstanding bus transaction has drained. Event bits in the status word are sticky and are cleared by writing 1. Each event bit has its own enable in the control word, and the interrupt line is the OR of the enabled event bits.

Top module: `dma_ring_ctrl`

## Requirements
- R1: After reset the status word reads 0001h, the current and last-valid indices read 0, the control word reads 0, `halted` is 1, and `fetch_en` and `irq` are 0.
- R2: Register addresses are 0 for the current index (read-only), 1 for the last-valid index, 2 for status and 3 for control. Each accepted buffer completion advances the current index by one, and the index wraps from 31 to 0. Index reads return zeros above bit 4.
- R3: The last-valid index keeps the low 5 bits of a write and reads back with zeros above bit 4.
- R4: Status bit 4 is the FIFO error, bit 3 is buffer completion, bit 2 is last-valid buffer done, bit 1 is current-equals-last-valid and bit 0 is halted. Bits 15:5 read 0.
- R5: A pulse on `fifo_fault` sets status bit 4. Writing 1 to that bit clears it.
- R6: An accepted completion sets status bit 3 only when `buf_ioc` is 1 in the same cycle. The bit holds until software writes 1 to it.
- R7: When the buffer at the last-valid index completes, the current index does not change, status bits 2 and 1 set, and `halted` rises at the same clock edge.
- R8: A write to the last-valid index clears status bit 1. If that bit was set, the write also advances the current index by one. `halted` clears on the first edge at which run is 1 and status bit 1 is 0.
- R9: After run is cleared, `halted` rises at the next edge if `xfer_pending` is 0. Otherwise it stays 0 until `xfer_pending` drops, then rises at the next edge.
- R10: Control bit 0 is run, and bits 1, 2 and 3 enable the interrupt for status bits 4, 3 and 2 respectively. `irq` is the OR of each of those status bits ANDed with its enable.
- R11: Writing 0 to a status event bit, or writing to the current index or to status bits 1 and 0, changes nothing.
- R12: `buf_done` is ignored unless run is 1 and `halted` is 0. `fetch_en` equals run AND NOT halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| buf_done | input | 1 | Last sample of the current buffer has finished |
| buf_ioc | input | 1 | Interrupt-on-completion flag of the current descriptor |
| fifo_fault | input | 1 | Sample FIFO under-run or over-run pulse |
| xfer_pending | input | 1 | A bus transaction is requested and not yet complete |
| fetch_en | output | 1 | Fetch engine may issue new requests |
| halted | output | 1 | Channel is halted |
| irq | output | 1 | Interrupt request |

## Verification
Several properties are checked on every cycle. `halted` and `fetch_en` are never both 1. The current index only ever steps by one. Current-equals-last-valid implies that the two indices match. Halting cannot end while run is 0, and a pending transaction holds off the halt. `irq` is only raised by a set event bit. The bench scenarios cover the rest: the exact status values along a full walk of the ring with alternating completion flags, the wrap when software re-arms the channel, the enable masking of the interrupt, writes that must not change anything, and the difference in timing between stopping with and without a pending transaction.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;
  typedef enum logic [1:0] {
    RA_CIDX = 2'd0,
    RA_LIDX = 2'd1,
    RA_STAT = 2'd2,
    RA_CTRL = 2'd3
  } reg_addr_e;

  // status bit positions
  localparam int ST_FERR = 4;
  localparam int ST_BCMP = 3;
  localparam int ST_LVB  = 2;
  localparam int ST_EQL  = 1;
  localparam int ST_HALT = 0;

  // sticky event vector order: 0 last-valid done, 1 completion, 2 fifo error
  localparam int EV_LVB  = 0;
  localparam int EV_BCMP = 1;
  localparam int EV_FERR = 2;
  localparam int EV_N    = 3;

  typedef struct packed {
    logic en_lvb;
    logic en_bcmp;
    logic en_ferr;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/dma_ring_index.sv
module dma_ring_index #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_ok,
  input  logic             lidx_wr,
  input  logic [IDX_W-1:0] lidx_wdata,
  output logic [IDX_W-1:0] cidx,
  output logic [IDX_W-1:0] lidx,
  output logic             eql,
  output logic             done_last
);
  logic [IDX_W-1:0] cidx_q, cidx_n;
  logic [IDX_W-1:0] lidx_q, lidx_n;
  logic             eql_q, eql_n;
  logic             cidx_en;

  assign done_last = done_ok && (cidx_q == lidx_q);

  always_comb begin
    lidx_n  = lidx_wr ? lidx_wdata : lidx_q;
    eql_n   = eql_q;
    cidx_n  = cidx_q + IDX_W'(1);
    cidx_en = 1'b0;
    if (lidx_wr) begin
      eql_n   = 1'b0;
      cidx_en = eql_q;
    end else if (done_last) begin
      eql_n   = 1'b1;
    end
    if (done_ok && !done_last) cidx_en = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cidx_q <= '0;
      lidx_q <= '0;
      eql_q  <= 1'b0;
    end else begin
      if (cidx_en) cidx_q <= cidx_n;
      if (lidx_wr) lidx_q <= lidx_n;
      eql_q <= eql_n;
    end
  end

  assign cidx = cidx_q;
  assign lidx = lidx_q;
  assign eql  = eql_q;
endmodule

// File: rtl/dma_ring_runctl.sv
module dma_ring_runctl (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic xfer_pending,
  input  logic eql,
  input  logic done_last,
  output logic halted
);
  logic halted_q, halted_n;

  always_comb begin
    halted_n = halted_q;
    if (halted_q) begin
      if (run && !eql) halted_n = 1'b0;
    end else if (done_last || eql || (!run && !xfer_pending)) begin
      halted_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halted_q <= 1'b1;
    else        halted_q <= halted_n;
  end

  assign halted = halted_q;
endmodule

// File: rtl/dma_ring_status.sv
module dma_ring_status #(
  parameter int EV_N = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_N-1:0] ev_set,
  input  logic [EV_N-1:0] ev_clr,
  input  logic [EV_N-1:0] ev_en,
  output logic [EV_N-1:0] ev_q,
  output logic            irq
);
  logic [EV_N-1:0] ev_n;

  for (genvar i = 0; i < EV_N; i++) begin : g_ev
    always_comb ev_n[i] = ev_set[i] | (ev_q[i] & ~ev_clr[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ev_q[i] <= 1'b0;
      else        ev_q[i] <= ev_n[i];
    end
  end

  assign irq = |(ev_q & ev_en);
endmodule

// File: rtl/dma_ring_ctrl.sv
module dma_ring_ctrl
  import dma_ring_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              buf_done,
  input  logic              buf_ioc,
  input  logic              fifo_fault,
  input  logic              xfer_pending,
  output logic              fetch_en,
  output logic              halted,
  output logic              irq
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t            ctrl_q, ctrl_n;
  logic             ctrl_wr, lidx_wr, stat_wr;
  logic             done_ok, done_last, eql;
  logic [IDX_W-1:0] cidx, lidx;
  logic [EV_N-1:0]  ev_set, ev_clr, ev_en, ev_q;
  logic [DATA_W-1:0] stat_word;
  logic             unused_wdata;

  assign ctrl_wr = reg_wr && (reg_addr == RA_CTRL);
  assign lidx_wr = reg_wr && (reg_addr == RA_LIDX);
  assign stat_wr = reg_wr && (reg_addr == RA_STAT);
  assign unused_wdata = ^reg_wdata;

  always_comb ctrl_n = ctrl_wr ? ctrl_t'(reg_wdata[CTRL_W-1:0]) : ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_n;
  end

  assign fetch_en = ctrl_q.run && !halted;
  assign done_ok  = buf_done && fetch_en;

  dma_ring_index #(.IDX_W(IDX_W)) u_index (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_ok    (done_ok),
    .lidx_wr    (lidx_wr),
    .lidx_wdata (reg_wdata[IDX_W-1:0]),
    .cidx       (cidx),
    .lidx       (lidx),
    .eql        (eql),
    .done_last  (done_last)
  );

  dma_ring_runctl u_runctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (ctrl_q.run),
    .xfer_pending (xfer_pending),
    .eql          (eql),
    .done_last    (done_last),
    .halted       (halted)
  );

  always_comb begin
    ev_set          = '0;
    ev_set[EV_LVB]  = done_last;
    ev_set[EV_BCMP] = done_ok && buf_ioc;
    ev_set[EV_FERR] = fifo_fault;
    ev_clr          = '0;
    ev_clr[EV_LVB]  = stat_wr && reg_wdata[ST_LVB];
    ev_clr[EV_BCMP] = stat_wr && reg_wdata[ST_BCMP];
    ev_clr[EV_FERR] = stat_wr && reg_wdata[ST_FERR];
    ev_en           = '0;
    ev_en[EV_LVB]   = ctrl_q.en_lvb;
    ev_en[EV_BCMP]  = ctrl_q.en_bcmp;
    ev_en[EV_FERR]  = ctrl_q.en_ferr;
  end

  dma_ring_status #(.EV_N(EV_N)) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_set (ev_set),
    .ev_clr (ev_clr),
    .ev_en  (ev_en),
    .ev_q   (ev_q),
    .irq    (irq)
  );

  always_comb begin
    stat_word          = '0;
    stat_word[ST_FERR] = ev_q[EV_FERR];
    stat_word[ST_BCMP] = ev_q[EV_BCMP];
    stat_word[ST_LVB]  = ev_q[EV_LVB];
    stat_word[ST_EQL]  = eql;
    stat_word[ST_HALT] = halted;
  end

  always_comb begin
    unique case (reg_addr)
      RA_CIDX: reg_rdata = DATA_W'(cidx);
      RA_LIDX: reg_rdata = DATA_W'(lidx);
      RA_STAT: reg_rdata = stat_word;
      default: reg_rdata = DATA_W'(ctrl_q);
    endcase
  end
endmodule

// File: rtl/dma_ring_chk.sv
module dma_ring_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             xfer_pending,
  input logic             halted,
  input logic             fetch_en,
  input logic             eql,
  input logic [IDX_W-1:0] cidx,
  input logic [IDX_W-1:0] lidx,
  input logic             irq,
  input logic [2:0]       ev_q
);
  assert_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(halted && fetch_en));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cidx != $past(cidx)) |-> (cidx == $past(cidx) + IDX_W'(1)));

  assert_eql_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eql |-> (cidx == lidx));

  assert_eql_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eql) |-> halted);

  assert_hold_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !run) |=> halted);

  assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && xfer_pending && !halted) |=> !halted);

  assert_irq_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ev_q != 3'b000));
endmodule

bind dma_ring_ctrl dma_ring_chk #(.IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .run          (ctrl_q.run),
  .xfer_pending (xfer_pending),
  .halted       (halted),
  .fetch_en     (fetch_en),
  .eql          (eql),
  .cidx         (cidx),
  .lidx         (lidx),
  .irq          (irq),
  .ev_q         (ev_q)
);

// File: tb/tb_dma_ring_ctrl.sv
`timescale 1ns/1ps
module tb_dma_ring_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        buf_done = 1'b0, buf_ioc = 1'b0, fifo_fault = 1'b0, xfer_pending = 1'b0;
  logic        fetch_en, halted, irq;
  int          n_chk = 0, n_bad = 0;
  logic [15:0] v;

  always #2 clk = ~clk;

  dma_ring_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_done(buf_done),
    .buf_ioc(buf_ioc), .fifo_fault(fifo_fault), .xfer_pending(xfer_pending),
    .fetch_en(fetch_en), .halted(halted), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h want %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic done(input logic ioc);
    buf_done = 1'b1; buf_ioc = ioc;
    tick();
    buf_done = 1'b0; buf_ioc = 1'b0;
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang want finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #5 rst_n = 1'b1;
    tick();
    // R1 reset state
    rd(2, v); check("R1 status", v, 16'h0001);
    rd(0, v); check("R1 cidx", v, 0);
    rd(1, v); check("R1 lidx", v, 0);
    rd(3, v); check("R1 ctrl", v, 0);
    check("R1 halted", halted, 1);
    check("R1 fetch_en", fetch_en, 0);
    check("R1 irq", irq, 0);

    // R3 last-valid width
    wr(1, 16'h00FF); rd(1, v); check("R3 lidx mask", v, 16'h001F);
    // R11 current index is read-only
    wr(0, 16'h0007); rd(0, v); check("R11 cidx ro", v, 0);
    wr(1, 16'd31);
    // R12 completion ignored while halted
    done(1'b1);
    rd(0, v); check("R12 cidx halted", v, 0);
    rd(2, v); check("R12 status halted", v, 16'h0001);

    // start: run + all enables
    wr(3, 16'h000F);
    check("R8 halted after run write", halted, 1);
    tick();
    check("R8 halted cleared", halted, 0);
    check("R12 fetch_en", fetch_en, 1);

    // R2/R6 walk the ring with alternating completion flags
    for (int i = 0; i < 31; i++) begin
      done(i[0]);
      rd(0, v); check("R2 cidx step", v, i + 1);
      rd(2, v); check("R6 completion bit", v[3], i[0]);
      check("R10 irq", irq, i[0]);
      if (i[0]) begin
        if (i == 1) begin
          wr(2, 16'h0000); rd(2, v); check("R11 zero write", v[3], 1);
        end
        wr(2, 16'h0008); rd(2, v); check("R6 w1c", v[3], 0);
      end
    end

    // R7 last valid buffer
    done(1'b0);
    rd(0, v); check("R7 cidx stays", v, 31);
    rd(2, v); check("R7 R4 status", v, 16'h0007);
    check("R7 halted", halted, 1);
    check("R10 irq lvb", irq, 1);
    done(1'b1);
    rd(0, v); check("R12 cidx while halted", v, 31);
    wr(2, 16'h0004); rd(2, v); check("R4 lvb cleared", v, 16'h0003);
    check("R10 irq off", irq, 0);
    wr(2, 16'hFFE3); rd(2, v); check("R11 ro status bits", v, 16'h0003);

    // R8 re-arm: wrap to 0
    wr(1, 16'd2);
    rd(0, v); check("R2 R8 wrap", v, 0);
    rd(2, v); check("R8 eql cleared", v, 16'h0001);
    tick();
    check("R8 resumed", halted, 0);

    // R5 / R10 fifo error and enable masking
    fifo_fault = 1'b1; tick(); fifo_fault = 1'b0;
    rd(2, v); check("R5 fifo set", v, 16'h0010);
    check("R10 irq fifo", irq, 1);
    wr(3, 16'h000D);
    check("R10 irq masked", irq, 0);
    wr(2, 16'h0010); rd(2, v); check("R5 fifo w1c", v, 16'h0000);

    // R9 stop with pending transaction
    xfer_pending = 1'b1;
    wr(3, 16'h0000);
    check("R9 not yet halted", halted, 0);
    done(1'b1);
    rd(0, v); check("R12 ignored when stopped", v, 0);
    tick(); tick();
    check("R9 waits on pending", halted, 0);
    check("R12 fetch_en off", fetch_en, 0);
    xfer_pending = 1'b0;
    tick();
    check("R9 halted after drain", halted, 1);

    // R9 stop without pending
    wr(3, 16'h0001); tick();
    check("R8 run again", halted, 0);
    wr(3, 16'h0000);
    check("R9 edge of write", halted, 0);
    tick();
    check("R9 immediate halt", halted, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule